// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The block accepts one load request for a whole warp: 32 lane byte addresses, each with an active bit. It groups the active lanes by the aligned 128-byte line their word falls into. For each distinct line it issues exactly one memory transaction. Transactions leave one per cycle on a valid/ready output. Each one carries the aligned line address and a 32-bit mask of the lanes that line serves.

Transactions come out in ascending order of the lowest lane each one serves. The final transaction is flagged. One cycle after that transaction is handed off, a done pulse reports two counts: the bytes the active lanes asked for and the bytes the transactions will move. Their ratio is the coalescing efficiency of the request. The block takes a new request only once the previous one has been fully handed off.

Top module: `warp_coalescer`

## Requirements
- R1: After a synchronous reset, req_ready is 1, txn_valid is 0 and done is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. For a request with at least one active lane, req_ready stays 0 from that edge until the edge that hands off the last transaction. While req_ready is 0, req_valid has no effect.
- R3: Each transaction's txn_addr is the byte address of an aligned 128-byte line, with bits [6:0] zero. Every active lane whose address has the same bits [31:7] is served by that one transaction. A 4-byte word never spans two lines.
- R4: Bit i of txn_mask is 1 exactly when lane i is active and its line is the transaction's line. Lanes that share a line, including lanes with identical addresses, share one transaction. Across one request the masks are disjoint and their union equals the active set.
- R5: Transactions are issued in ascending order of the lowest-numbered lane each one serves, whatever the address order.
- R6: A lane whose req_active bit is 0 appears in no mask, causes no transaction and adds nothing to the requested byte count.
- R7: While txn_valid is 1 and txn_ready is 0, txn_valid, txn_addr, txn_mask and txn_last hold their values.
- R8: txn_last is 1 only on the final transaction of a request. done is 1 for the cycle after the edge that hands that transaction off.
- R9: In the done cycle, req_bytes equals 4 times the number of active lanes and xfer_bytes equals 128 times the number of transactions issued.
- R10: A request with no active lane issues no transaction. done is 1 in the cycle after the request is taken, with both counts 0, and req_ready stays 1.
- R11: 32 active lanes reading consecutive words from a 128-byte aligned base give one transaction with counts 128/128. A 128-byte lane stride gives 32 transactions with counts 128/4096.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A warp request is offered |
| req_ready | output | 1 | The block can take a request |
| req_addr | input | 1024 | Lane byte addresses, lane i in bits [32*i+31:32*i] |
| req_active | input | 32 | Lane active bits, bit i for lane i |
| txn_valid | output | 1 | A transaction is offered |
| txn_ready | input | 1 | The memory side takes the transaction |
| txn_addr | output | 32 | Aligned 128-byte line byte address |
| txn_mask | output | 32 | Lanes served by this transaction |
| txn_last | output | 1 | Final transaction of the request |
| done | output | 1 | One-cycle pulse after the final hand-off |
| req_bytes | output | 13 | Bytes requested by active lanes, valid with done |
| xfer_bytes | output | 13 | Bytes moved by the transactions, valid with done |

## Verification
The bench targets a base 64 bytes into a line, where a design that slices the wrong address bits would produce one transaction instead of two. It builds a warp whose upper lanes sit at lower addresses, so a design that sorts by address instead of by lane emits the lines in the wrong order. It drives scattered, duplicated and partly inactive addresses under backpressure while holding a second request pending. A design that leaked masked lanes, double-issued a line, dropped a stalled transaction or took the pending request early would show a wrong mask, a changed value or a wrong count. The all-inactive warp catches a design that hangs or emits an empty transaction.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int unsigned DEF_LANES      = 32;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_LINE_BYTES = 128;
  localparam int unsigned DEF_WORD_BYTES = 4;
endpackage

// File: rtl/coal_tag_store.sv
module coal_tag_store #(
  parameter int unsigned LANES  = coal_pkg::DEF_LANES,
  parameter int unsigned ADDR_W = coal_pkg::DEF_ADDR_W,
  parameter int unsigned OFF_W  = 7,
  localparam int unsigned TAG_W = ADDR_W - OFF_W
) (
  input  logic                          clk,
  input  logic                          load,
  input  logic [LANES*ADDR_W-1:0]       addr_flat,
  output logic [LANES-1:0][TAG_W-1:0]   tags
);
  logic [LANES-1:0][OFF_W-1:0] unused_offsets;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign unused_offsets[g] = addr_flat[g*ADDR_W +: OFF_W];
    always_ff @(posedge clk) begin
      if (load) tags[g] <= addr_flat[g*ADDR_W + OFF_W +: TAG_W];
    end
  end
endmodule

// File: rtl/coal_leader_pick.sv
module coal_leader_pick #(
  parameter int unsigned LANES = coal_pkg::DEF_LANES,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  pending,
  output logic              found,
  output logic [LANE_W-1:0] idx
);
  always_comb begin
    found = |pending;
    idx   = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) idx = LANE_W'(i);
    end
  end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
  parameter int unsigned LANES = coal_pkg::DEF_LANES,
  parameter int unsigned TAG_W = 25,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0][TAG_W-1:0] tags,
  input  logic [LANES-1:0]            pending,
  input  logic [LANE_W-1:0]           leader,
  output logic [TAG_W-1:0]            leader_tag,
  output logic [LANES-1:0]            hit
);
  assign leader_tag = tags[leader];

  for (genvar g = 0; g < LANES; g++) begin : g_cmp
    assign hit[g] = pending[g] && (tags[g] == leader_tag);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int unsigned LANES      = coal_pkg::DEF_LANES,
  parameter int unsigned ADDR_W     = coal_pkg::DEF_ADDR_W,
  parameter int unsigned LINE_BYTES = coal_pkg::DEF_LINE_BYTES,
  parameter int unsigned WORD_BYTES = coal_pkg::DEF_WORD_BYTES,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W     = ADDR_W - OFF_W,
  localparam int unsigned LANE_W    = $clog2(LANES),
  localparam int unsigned CNT_W     = $clog2(LANES * LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_active,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic [LANES-1:0]        txn_mask,
  output logic                    txn_last,
  output logic                    done,
  output logic [CNT_W-1:0]        req_bytes,
  output logic [CNT_W-1:0]        xfer_bytes
);
  logic                        busy;
  logic [LANES-1:0]            pending;
  logic [LANES-1:0][TAG_W-1:0] tags;
  logic                        lead_found;
  logic [LANE_W-1:0]           lead_idx;
  logic [TAG_W-1:0]            lead_tag;
  logic [LANES-1:0]            hit;

  logic             out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [LANES-1:0] out_mask;
  logic             out_last;
  logic             done_q;
  logic [CNT_W-1:0] req_cnt;
  logic [CNT_W-1:0] xfer_cnt;

  logic accept, load_txn, last_hand;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign load_txn  = busy && lead_found && (!out_valid || txn_ready);
  assign last_hand = out_valid && txn_ready && out_last;

  coal_tag_store #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tags (
    .clk(clk), .load(accept), .addr_flat(req_addr), .tags(tags)
  );

  coal_leader_pick #(.LANES(LANES)) u_pick (
    .pending(pending), .found(lead_found), .idx(lead_idx)
  );

  coal_line_match #(.LANES(LANES), .TAG_W(TAG_W)) u_match (
    .tags(tags), .pending(pending), .leader(lead_idx),
    .leader_tag(lead_tag), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pending   <= '0;
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_mask  <= '0;
      out_last  <= 1'b0;
      done_q    <= 1'b0;
      req_cnt   <= '0;
      xfer_cnt  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        pending  <= req_active;
        req_cnt  <= CNT_W'($countones(req_active)) * CNT_W'(WORD_BYTES);
        xfer_cnt <= '0;
        if (req_active == '0) done_q <= 1'b1;
        else                  busy   <= 1'b1;
      end
      if (load_txn) begin
        out_valid <= 1'b1;
        out_tag   <= lead_tag;
        out_mask  <= hit;
        out_last  <= ((pending & ~hit) == '0);
        pending   <= pending & ~hit;
        xfer_cnt  <= xfer_cnt + CNT_W'(LINE_BYTES);
      end else if (txn_ready) begin
        out_valid <= 1'b0;
      end
      if (last_hand) begin
        busy   <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign txn_valid  = out_valid;
  assign txn_addr   = {out_tag, {OFF_W{1'b0}}};
  assign txn_mask   = out_mask;
  assign txn_last   = out_last;
  assign done       = done_q;
  assign req_bytes  = req_cnt;
  assign xfer_bytes = xfer_cnt;
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int unsigned LANES      = 32,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 128,
  parameter int unsigned CNT_W      = 13,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_active,
  input logic              txn_valid,
  input logic              txn_ready,
  input logic [ADDR_W-1:0] txn_addr,
  input logic [LANES-1:0]  txn_mask,
  input logic              txn_last,
  input logic              done,
  input logic [CNT_W-1:0]  xfer_bytes
);
  logic [LANES-1:0] act_q;
  logic [LANES-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      seen  <= '0;
    end else if (req_valid && req_ready) begin
      act_q <= req_active;
      seen  <= '0;
    end else if (txn_valid && txn_ready) begin
      seen <= seen | txn_mask;
    end
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst) txn_valid |-> !req_ready); // R2
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst) txn_valid |-> (txn_addr[OFF_W-1:0] == '0)); // R3
  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (rst) txn_valid |-> (txn_mask != '0)); // R4
  AST_MASK_DISJOINT: assert property (@(posedge clk) disable iff (rst) (txn_valid && txn_ready) |-> ((txn_mask & seen) == '0)); // R4
  AST_LAST_COVERS: assert property (@(posedge clk) disable iff (rst) (txn_valid && txn_ready && txn_last) |-> ((seen | txn_mask) == act_q)); // R4
  AST_MASK_ACTIVE: assert property (@(posedge clk) disable iff (rst) txn_valid |-> ((txn_mask & ~act_q) == '0)); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst) (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_mask) && $stable(txn_last))); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) (txn_valid && txn_ready && txn_last) |=> done); // R8
  AST_XFER_LINES: assert property (@(posedge clk) disable iff (rst) done |-> ((xfer_bytes[OFF_W-1:0] == '0) && (xfer_bytes <= CNT_W'(LANES * LINE_BYTES)))); // R9
endmodule

bind warp_coalescer coal_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_active(req_active), .txn_valid(txn_valid), .txn_ready(txn_ready),
  .txn_addr(txn_addr), .txn_mask(txn_mask), .txn_last(txn_last),
  .done(done), .xfer_bytes(xfer_bytes)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1023:0] req_addr = '0;
  logic [31:0]   req_active = '0;
  logic          txn_valid;
  logic          txn_ready = 1'b1;
  logic [31:0]   txn_addr;
  logic [31:0]   txn_mask;
  logic          txn_last;
  logic          done;
  logic [12:0]   req_bytes;
  logic [12:0]   xfer_bytes;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] exp_line [NL];
  logic [31:0] exp_mask [NL];
  int          exp_n;

  always #4 clk = ~clk;

  warp_coalescer u_warp_coalescer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_active(req_active), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_addr(txn_addr), .txn_mask(txn_mask),
    .txn_last(txn_last), .done(done), .req_bytes(req_bytes), .xfer_bytes(xfer_bytes)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Runs one warp request and checks every transaction and the done report.
  task automatic run_req(input logic [1023:0] a, input logic [31:0] act,
                         input bit bp, input bit junk);
    int got = 0;
    int cyc = 0;
    int nact = 0;
    bit stalled = 0;
    logic [31:0] s_addr = '0;
    logic [31:0] s_mask = '0;
    logic        s_last = 1'b0;
    exp_n = 0;
    for (int i = 0; i < NL; i++) begin
      if (act[i]) begin
        logic [31:0] ln = a[i*32 +: 32] & 32'hFFFF_FF80;
        int f = -1;
        nact++;
        for (int j = 0; j < exp_n; j++) if (exp_line[j] == ln) f = j;
        if (f < 0) begin
          exp_line[exp_n] = ln;
          exp_mask[exp_n] = 32'h1 << i;
          exp_n++;
        end else begin
          exp_mask[f][i] = 1'b1;
        end
      end
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_active = act;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_n == 0) begin
      chk(done == 1'b1, "R10 done after empty request", done, 1);
      chk(txn_valid == 1'b0, "R10 no transaction", txn_valid, 0);
      chk(req_bytes == 0 && xfer_bytes == 0, "R10 zero counts", {req_bytes, xfer_bytes}, 0);
      chk(req_ready == 1'b1, "R10 ready stays high", req_ready, 1);
      return;
    end
    chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    if (junk) begin
      req_valid = 1'b1; req_active = 32'hFFFF_FFFF; req_addr = '0;
    end
    while (got < exp_n && cyc < 500) begin
      bit rdy = bp ? ((cyc % 3) != 1) : 1'b1;
      txn_ready = rdy;
      if (stalled && txn_valid) begin
        chk(txn_addr == s_addr && txn_mask == s_mask && txn_last == s_last,
            "R7 held under stall", {txn_addr, txn_mask}, {s_addr, s_mask});
      end
      stalled = 0;
      if (txn_valid && rdy) begin
        chk(txn_addr == exp_line[got], "R3/R5 line address in order", txn_addr, exp_line[got]);
        chk(txn_mask == exp_mask[got], "R4/R6 lane mask", txn_mask, exp_mask[got]);
        chk(txn_last == (got == exp_n - 1), "R8 last flag", txn_last, got == exp_n - 1);
        chk(done == 1'b0, "R8 no early done", done, 0);
        got++;
        if (got == exp_n) req_valid = 1'b0;
      end else if (txn_valid) begin
        stalled = 1; s_addr = txn_addr; s_mask = txn_mask; s_last = txn_last;
      end
      @(negedge clk);
      cyc++;
    end
    txn_ready = 1'b1;
    chk(got == exp_n, "R3 transaction count", got, exp_n);
    chk(done == 1'b1, "R8 done after last hand-off", done, 1);
    chk(req_bytes == 13'(4 * nact), "R9 requested bytes", req_bytes, 4 * nact);
    chk(xfer_bytes == 13'(128 * exp_n), "R9 transferred bytes", xfer_bytes, 128 * exp_n);
    chk(txn_valid == 1'b0, "R8 no transaction after last", txn_valid, 0);
    chk(req_ready == 1'b1, "R2 ready after last", req_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(txn_valid == 1'b0, "R1 reset txn_valid", txn_valid, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
  endtask

  task automatic t_consecutive();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++) a[i*32 +: 32] = 32'h0000_1000 + 32'(4 * i);
    run_req(a, 32'hFFFF_FFFF, 0, 0);
    chk(xfer_bytes == 13'd128 && req_bytes == 13'd128, "R11 coalesced 128/128", xfer_bytes, 128);
  endtask

  task automatic t_stride();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++) a[i*32 +: 32] = 32'h0002_0000 + 32'(128 * i);
    run_req(a, 32'hFFFF_FFFF, 1, 0);
    chk(xfer_bytes == 13'd4096 && req_bytes == 13'd128, "R11 strided 128/4096", xfer_bytes, 4096);
  endtask

  task automatic t_offset_base();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++) a[i*32 +: 32] = 32'h0000_3040 + 32'(4 * i);
    run_req(a, 32'hFFFF_FFFF, 0, 0);
    chk(exp_n == 2, "R3 offset base spans two lines", exp_n, 2);
  endtask

  task automatic t_reverse();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++)
      a[i*32 +: 32] = (i < 16) ? 32'h0000_9000 + 32'(4 * i) : 32'h0000_5000 + 32'(4 * i);
    run_req(a, 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_empty();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++) a[i*32 +: 32] = 32'(i * 128);
    run_req(a, 32'h0, 0, 0);
  endtask

  task automatic t_same_addr();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++) a[i*32 +: 32] = 32'h0000_7A0C;
    run_req(a, 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_half_active();
    logic [1023:0] a;
    for (int i = 0; i < NL; i++) a[i*32 +: 32] = 32'h0005_0000 + 32'(128 * i);
    run_req(a, 32'h0000_FFFF, 1, 0);
  endtask

  task automatic t_scatter();
    logic [1023:0] a;
    logic [31:0] seed = 32'h1234_5678;
    for (int i = 0; i < NL; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      a[i*32 +: 32] = 32'h0004_0000 + ((seed >> 16) % 8) * 128 + ((seed >> 8) % 32) * 4;
    end
    run_req(a, 32'hA5F3_0C7E, 1, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_consecutive();
    t_stride();
    t_offset_base();
    t_reverse();
    t_empty();
    t_same_addr();
    t_half_active();
    t_scatter();
    t_empty();
    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end
endmodule